// File: doc/BRIEF.md
# I2C Interrupt Vector and Status Unit

This unit sits beside the byte and bit engine of an I2C controller and turns that engine's single-cycle event pulses into sticky pending flags. The seven event kinds are arbitration lost, no-acknowledge, access ready, receive data ready, transmit ready, stop condition seen and addressed as slave. A mask register picks which pending flags may raise the one interrupt line. A vector register reports a single encoded event at a time, always the most urgent enabled one.

Software services the unit through a small register port. It reads the vector, acts on the code it gets, and reads again until the code is zero. Each vector read acknowledges the event it returns. Some flags can also be dropped by writing ones to the status register. The receive-ready and transmit-ready flags drop when the controller's data registers are read or loaded, which the controller reports on two strobe inputs.

Top module: `i2c_irq_vector`

## Requirements
- R1: After reset the mask register, every pending flag, the vector code and `irq` are all zero.
- R2: An event pulse sets its pending flag on the next clock edge whatever the mask holds, and the flag stays set until it is cleared. In the status register (offset 0x08) the flags sit at arbitration lost bit 0, no-acknowledge bit 1, access ready bit 2, receive ready bit 3, transmit ready bit 4, stop seen bit 5 and addressed as slave bit 6.
- R3: The mask register at offset 0x04 is read/write in bits 6:0, with the same bit layout as the status flags. Its bits 15:7 read as zero.
- R4: `irq` is high exactly when at least one pending flag has its mask bit set.
- R5: The vector register at offset 0x28 returns, in bits 2:0, the bit index plus one of the lowest-numbered flag that is both pending and enabled. So 1 means arbitration lost and 7 means addressed as slave. It returns 0 when no such flag exists.
- R6: A vector read clears only the flag whose code it returns. A read that returns 0 changes nothing.
- R7: A status write clears each of bits 0, 1, 2, 5 and 6 whose write-data bit is 1. Bits 3 and 4, and write-data bits of 0, have no effect.
- R8: A pulse on `rx_data_taken` clears the receive-ready flag. A pulse on `tx_data_loaded` clears the transmit-ready flag.
- R9: Status bit 11 reads the `rx_shift_full` input and status bit 12 reads the `bus_busy` input. All other status bits above 6 read as zero.
- R10: When an event pulse lands in the same cycle as any clear of the same flag (vector read, status write or data strobe), the flag remains set.
- R11: A read of an unmapped offset returns zero. A write to an unmapped offset changes no register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | 6 | Register byte offset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (read side effects) |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data for `reg_addr`, combinational |
| ev_arb_lost | input | 1 | Arbitration lost pulse |
| ev_nack | input | 1 | No-acknowledge pulse |
| ev_acc_ready | input | 1 | Access ready pulse |
| ev_rx_ready | input | 1 | Receive data ready pulse |
| ev_tx_ready | input | 1 | Transmit ready pulse |
| ev_stop_seen | input | 1 | Stop condition detected pulse |
| ev_addr_slave | input | 1 | Addressed as slave pulse |
| rx_data_taken | input | 1 | Receive data register was read |
| tx_data_loaded | input | 1 | Transmit data register was written |
| rx_shift_full | input | 1 | Receive shift register full level |
| bus_busy | input | 1 | Bus busy level |
| irq | output | 1 | Interrupt request |

## Verification
The risky overlap is an event pulse arriving in the same cycle as the clear of its own flag. The clear can come from a vector read that acknowledges it, from a status write of one, or from a data strobe. The bench drives the pulse and the clear in one cycle, then reads the status register. It judges the flag correct only if it is still set, so the fresh event has not been lost to the acknowledgement of the older one.

// File: rtl/i2cv_pkg.sv
`timescale 1ns/1ps
package i2cv_pkg;
  // number of event kinds tracked
  localparam int unsigned NEV = 7;

  // flag positions, shared by pending, mask and status layouts
  localparam int unsigned IDX_ARB   = 0;
  localparam int unsigned IDX_NACK  = 1;
  localparam int unsigned IDX_ARDY  = 2;
  localparam int unsigned IDX_RRDY  = 3;
  localparam int unsigned IDX_XRDY  = 4;
  localparam int unsigned IDX_STOP  = 5;
  localparam int unsigned IDX_SLAVE = 6;

  // flags that a status write of one may drop
  localparam logic [NEV-1:0] W1C_BITS = (NEV'(1) << IDX_ARB)  | (NEV'(1) << IDX_NACK) |
                                        (NEV'(1) << IDX_ARDY) | (NEV'(1) << IDX_STOP) |
                                        (NEV'(1) << IDX_SLAVE);
endpackage

// File: rtl/i2cv_flag_bank.sv
`timescale 1ns/1ps
module i2cv_flag_bank #(
  parameter int unsigned N = 7
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] flags_o
);
  for (genvar i = 0; i < N; i++) begin : g_flag
    logic q;
    logic d;
    logic en;

    // a new event outranks any clear in the same cycle
    always_comb begin
      en = set_i[i] | clr_i[i];
      d  = set_i[i] | (q & ~clr_i[i]);
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        q <= 1'b0;
      end else if (en) begin
        q <= d;
      end
    end

    assign flags_o[i] = q;
  end
endmodule

// File: rtl/i2cv_prio_enc.sv
`timescale 1ns/1ps
module i2cv_prio_enc #(
  parameter int unsigned N  = 7,
  parameter int unsigned CW = 3
) (
  input  logic [N-1:0]  req_i,
  output logic [CW-1:0] code_o,
  output logic [N-1:0]  onehot_o
);
  logic found;

  // lowest index wins; code is index plus one, zero means idle
  always_comb begin
    code_o   = '0;
    onehot_o = '0;
    found    = 1'b0;
    for (int i = 0; i < int'(N); i++) begin
      if (!found && req_i[i]) begin
        code_o      = CW'(i + 1);
        onehot_o[i] = 1'b1;
        found       = 1'b1;
      end
    end
  end
endmodule

// File: rtl/i2cv_regif.sv
`timescale 1ns/1ps
module i2cv_regif
  import i2cv_pkg::*;
#(
  parameter int unsigned DATA_W   = 16,
  parameter int unsigned ADDR_W   = 6,
  parameter int unsigned CW       = 3,
  parameter logic [ADDR_W-1:0] MASK_OFS = 6'h04,
  parameter logic [ADDR_W-1:0] STAT_OFS = 6'h08,
  parameter logic [ADDR_W-1:0] VEC_OFS  = 6'h28,
  parameter int unsigned RSF_BIT  = 11,
  parameter int unsigned BB_BIT   = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_i,
  input  logic              rd_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic [NEV-1:0]    flags_i,
  input  logic [CW-1:0]     code_i,
  input  logic [NEV-1:0]    code_oh_i,
  input  logic              rx_taken_i,
  input  logic              tx_loaded_i,
  input  logic              rsfull_i,
  input  logic              busy_i,
  output logic [NEV-1:0]    mask_o,
  output logic [NEV-1:0]    clr_o
);
  logic [NEV-1:0] mask_q;
  logic [NEV-1:0] mask_d;
  logic           mask_we;
  logic           stat_we;
  logic           vec_rd;
  logic [NEV-1:0] data_clr;
  logic [DATA_W-NEV-1:0] unused_wdata_hi;

  assign unused_wdata_hi = wdata_i[DATA_W-1:NEV];

  // decode
  always_comb begin
    mask_we = wr_i && (addr_i == MASK_OFS);
    stat_we = wr_i && (addr_i == STAT_OFS);
    vec_rd  = rd_i && (addr_i == VEC_OFS);
  end

  // mask register
  always_comb begin
    mask_d = mask_we ? wdata_i[NEV-1:0] : mask_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= '0;
    end else if (mask_we) begin
      mask_q <= mask_d;
    end
  end

  assign mask_o = mask_q;

  // clear sources
  always_comb begin
    data_clr           = '0;
    data_clr[IDX_RRDY] = rx_taken_i;
    data_clr[IDX_XRDY] = tx_loaded_i;
    clr_o = ({NEV{vec_rd}} & code_oh_i)
          | ({NEV{stat_we}} & wdata_i[NEV-1:0] & W1C_BITS)
          | data_clr;
  end

  // read mux
  always_comb begin
    rdata_o = '0;
    case (addr_i)
      MASK_OFS: rdata_o[NEV-1:0] = mask_q;
      STAT_OFS: begin
        rdata_o[NEV-1:0] = flags_i;
        rdata_o[RSF_BIT] = rsfull_i;
        rdata_o[BB_BIT]  = busy_i;
      end
      VEC_OFS:  rdata_o[CW-1:0] = code_i;
      default:  rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/i2c_irq_vector.sv
`timescale 1ns/1ps
module i2c_irq_vector
  import i2cv_pkg::*;
#(
  parameter int unsigned DATA_W   = 16,
  parameter int unsigned ADDR_W   = 6,
  parameter logic [ADDR_W-1:0] MASK_OFS = 6'h04,
  parameter logic [ADDR_W-1:0] STAT_OFS = 6'h08,
  parameter logic [ADDR_W-1:0] VEC_OFS  = 6'h28,
  parameter int unsigned RSF_BIT  = 11,
  parameter int unsigned BB_BIT   = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic              ev_arb_lost,
  input  logic              ev_nack,
  input  logic              ev_acc_ready,
  input  logic              ev_rx_ready,
  input  logic              ev_tx_ready,
  input  logic              ev_stop_seen,
  input  logic              ev_addr_slave,
  input  logic              rx_data_taken,
  input  logic              tx_data_loaded,
  input  logic              rx_shift_full,
  input  logic              bus_busy,
  output logic              irq
);
  localparam int unsigned CODE_W = $clog2(NEV + 1);

  logic [NEV-1:0]    ev_vec;
  logic [NEV-1:0]    pend_flags;
  logic [NEV-1:0]    irq_mask;
  logic [NEV-1:0]    flag_clr;
  logic [NEV-1:0]    live;
  logic [NEV-1:0]    vec_oh;
  logic [CODE_W-1:0] vec_code;

  always_comb begin
    ev_vec            = '0;
    ev_vec[IDX_ARB]   = ev_arb_lost;
    ev_vec[IDX_NACK]  = ev_nack;
    ev_vec[IDX_ARDY]  = ev_acc_ready;
    ev_vec[IDX_RRDY]  = ev_rx_ready;
    ev_vec[IDX_XRDY]  = ev_tx_ready;
    ev_vec[IDX_STOP]  = ev_stop_seen;
    ev_vec[IDX_SLAVE] = ev_addr_slave;
  end

  i2cv_flag_bank #(.N(NEV)) u_flags (
    .clk     (clk),
    .rst_n   (rst_n),
    .set_i   (ev_vec),
    .clr_i   (flag_clr),
    .flags_o (pend_flags)
  );

  assign live = pend_flags & irq_mask;
  assign irq  = |live;

  i2cv_prio_enc #(.N(NEV), .CW(CODE_W)) u_prio (
    .req_i    (live),
    .code_o   (vec_code),
    .onehot_o (vec_oh)
  );

  i2cv_regif #(
    .DATA_W   (DATA_W),
    .ADDR_W   (ADDR_W),
    .CW       (CODE_W),
    .MASK_OFS (MASK_OFS),
    .STAT_OFS (STAT_OFS),
    .VEC_OFS  (VEC_OFS),
    .RSF_BIT  (RSF_BIT),
    .BB_BIT   (BB_BIT)
  ) u_regs (
    .clk         (clk),
    .rst_n       (rst_n),
    .addr_i      (reg_addr),
    .wr_i        (reg_wr),
    .rd_i        (reg_rd),
    .wdata_i     (reg_wdata),
    .rdata_o     (reg_rdata),
    .flags_i     (pend_flags),
    .code_i      (vec_code),
    .code_oh_i   (vec_oh),
    .rx_taken_i  (rx_data_taken),
    .tx_loaded_i (tx_data_loaded),
    .rsfull_i    (rx_shift_full),
    .busy_i      (bus_busy),
    .mask_o      (irq_mask),
    .clr_o       (flag_clr)
  );
endmodule

// File: rtl/i2cv_checker.sv
`timescale 1ns/1ps
module i2cv_checker #(
  parameter int unsigned NEV    = 7,
  parameter int unsigned ADDR_W = 6,
  parameter int unsigned CW     = 3,
  parameter logic [ADDR_W-1:0] VEC_OFS = 6'h28
) (
  input logic              clk,
  input logic              rst_n,
  input logic [NEV-1:0]    ev,
  input logic [NEV-1:0]    flags,
  input logic [NEV-1:0]    mask,
  input logic [CW-1:0]     code,
  input logic              irq,
  input logic              reg_rd,
  input logic              reg_wr,
  input logic [ADDR_W-1:0] reg_addr,
  input logic              rx_taken,
  input logic              tx_loaded
);
  logic [NEV-1:0] oh;
  logic           vec_rd;
  logic           quiet;

  always_comb begin
    oh = '0;
    for (int i = 0; i < int'(NEV); i++) begin
      if (code == CW'(i + 1)) oh[i] = 1'b1;
    end
    vec_rd = reg_rd && (reg_addr == VEC_OFS);
    quiet  = (ev == '0) && !reg_rd && !reg_wr && !rx_taken && !tx_loaded;
  end

  AST_EVENT_LATCHES: assert property (@(posedge clk) disable iff (!rst_n)
    (ev != '0) |=> ((flags & $past(ev)) == $past(ev))); // R2

  AST_FLAGS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    quiet |=> $stable(flags)); // R2

  AST_IRQ_VS_VECTOR: assert property (@(posedge clk) disable iff (!rst_n)
    irq == (code != '0)); // R4

  AST_LOWEST_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (code != '0) |-> (((flags & mask & (oh - 1'b1)) == '0) && ((flags & mask & oh) != '0))); // R5

  AST_VEC_READ_ACKS: assert property (@(posedge clk) disable iff (!rst_n)
    (vec_rd && (code != '0) && ((ev & oh) == '0)) |=> ((flags & $past(oh)) == '0)); // R6

  AST_RX_STROBE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_taken && !ev[3]) |=> !flags[3]); // R8

  AST_CLASH_KEEPS_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
    (vec_rd && ((ev & oh) != '0)) |=> ((flags & $past(oh)) != '0)); // R10
endmodule

bind i2c_irq_vector i2cv_checker #(
  .NEV     (i2cv_pkg::NEV),
  .ADDR_W  (ADDR_W),
  .CW      (CODE_W),
  .VEC_OFS (VEC_OFS)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .ev        (ev_vec),
  .flags     (pend_flags),
  .mask      (irq_mask),
  .code      (vec_code),
  .irq       (irq),
  .reg_rd    (reg_rd),
  .reg_wr    (reg_wr),
  .reg_addr  (reg_addr),
  .rx_taken  (rx_data_taken),
  .tx_loaded (tx_data_loaded)
);

// File: tb/tb_i2c_irq_vector.sv
`timescale 1ns/1ps
module tb_i2c_irq_vector;
  localparam logic [5:0] A_MASK = 6'h04;
  localparam logic [5:0] A_STAT = 6'h08;
  localparam logic [5:0] A_VEC  = 6'h28;
  localparam logic [5:0] A_NONE = 6'h0C;

  logic        clk;
  logic        rst_n;
  logic [5:0]  reg_addr;
  logic        reg_wr;
  logic        reg_rd;
  logic [15:0] reg_wdata;
  logic [15:0] reg_rdata;
  logic [6:0]  ev;
  logic        rx_data_taken;
  logic        tx_data_loaded;
  logic        rx_shift_full;
  logic        bus_busy;
  logic        irq;

  int n_checks = 0;
  int n_err    = 0;

  i2c_irq_vector dut (
    .clk            (clk),
    .rst_n          (rst_n),
    .reg_addr       (reg_addr),
    .reg_wr         (reg_wr),
    .reg_rd         (reg_rd),
    .reg_wdata      (reg_wdata),
    .reg_rdata      (reg_rdata),
    .ev_arb_lost    (ev[0]),
    .ev_nack        (ev[1]),
    .ev_acc_ready   (ev[2]),
    .ev_rx_ready    (ev[3]),
    .ev_tx_ready    (ev[4]),
    .ev_stop_seen   (ev[5]),
    .ev_addr_slave  (ev[6]),
    .rx_data_taken  (rx_data_taken),
    .tx_data_loaded (tx_data_loaded),
    .rx_shift_full  (rx_shift_full),
    .bus_busy       (bus_busy),
    .irq            (irq)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual 0x%04h expected 0x%04h", req, act, exp);
    end
  endtask

  // one bus cycle: drive at falling edge, sample read data before the rising edge
  task automatic cyc(input logic [6:0] e, input logic rd, input logic wr,
                     input logic [5:0] a, input logic [15:0] wd,
                     input logic rx, input logic tx, output logic [15:0] rv);
    @(negedge clk);
    ev = e; reg_rd = rd; reg_wr = wr; reg_addr = a; reg_wdata = wd;
    rx_data_taken = rx; tx_data_loaded = tx;
    #1 rv = reg_rdata;
    @(negedge clk);
    ev = '0; reg_rd = 1'b0; reg_wr = 1'b0; reg_addr = A_NONE; reg_wdata = '0;
    rx_data_taken = 1'b0; tx_data_loaded = 1'b0;
    #1;
  endtask

  task automatic rd(input logic [5:0] a, output logic [15:0] v);
    cyc('0, 1'b1, 1'b0, a, '0, 1'b0, 1'b0, v);
  endtask

  task automatic wr(input logic [5:0] a, input logic [15:0] d);
    logic [15:0] dummy;
    cyc('0, 1'b0, 1'b1, a, d, 1'b0, 1'b0, dummy);
  endtask

  task automatic pulse(input logic [6:0] e);
    logic [15:0] dummy;
    cyc(e, 1'b0, 1'b0, A_NONE, '0, 1'b0, 1'b0, dummy);
  endtask

  task automatic t_reset();
    logic [15:0] v;
    check("R1 irq", {15'd0, irq}, 16'h0000);
    rd(A_MASK, v); check("R1 mask", v, 16'h0000);
    rd(A_STAT, v); check("R1 status", v, 16'h0000);
    rd(A_VEC, v);  check("R1 vector", v, 16'h0000);
  endtask

  task automatic t_masked_latch();
    logic [15:0] v;
    pulse(7'h21);
    rd(A_STAT, v); check("R2 flags latch while masked", v, 16'h0021);
    check("R4 irq low when masked", {15'd0, irq}, 16'h0000);
    rd(A_VEC, v);  check("R5 vector idle when masked", v, 16'h0000);
    rd(A_STAT, v); check("R6 idle vector read keeps flags", v, 16'h0021);
  endtask

  task automatic t_mask_and_ack();
    logic [15:0] v;
    wr(A_MASK, 16'hFFFF);
    rd(A_MASK, v); check("R3 mask readback", v, 16'h007F);
    check("R4 irq high", {15'd0, irq}, 16'h0001);
    rd(A_VEC, v);  check("R5 first code", v, 16'h0001);
    rd(A_STAT, v); check("R6 only reported flag cleared", v, 16'h0020);
    rd(A_VEC, v);  check("R5 second code", v, 16'h0006);
    rd(A_STAT, v); check("R6 status empty", v, 16'h0000);
    check("R4 irq low after acks", {15'd0, irq}, 16'h0000);
  endtask

  task automatic t_priority_walk();
    logic [15:0] v;
    pulse(7'h7F);
    for (int k = 1; k <= 7; k++) begin
      rd(A_VEC, v); check("R5 priority order", v, 16'(k));
    end
    rd(A_VEC, v); check("R6 drained", v, 16'h0000);
  endtask

  task automatic t_mask_select();
    logic [15:0] v;
    wr(A_MASK, 16'h0050);
    pulse(7'h42);
    check("R4 irq via enabled flag", {15'd0, irq}, 16'h0001);
    rd(A_VEC, v);  check("R5 masked lower flag skipped", v, 16'h0007);
    rd(A_STAT, v); check("R6 masked flag kept", v, 16'h0002);
    check("R4 irq low with only masked flag", {15'd0, irq}, 16'h0000);
    wr(A_STAT, 16'h0002);
    rd(A_STAT, v); check("R7 nack write-one clears", v, 16'h0000);
  endtask

  task automatic t_w1c_and_strobes();
    logic [15:0] v;
    logic [15:0] dummy;
    pulse(7'h7F);
    wr(A_STAT, 16'h0000);
    rd(A_STAT, v); check("R7 zero write no effect", v, 16'h007F);
    wr(A_STAT, 16'hFFFF);
    rd(A_STAT, v); check("R7 rx/tx flags survive status write", v, 16'h0018);
    cyc('0, 1'b0, 1'b0, A_NONE, '0, 1'b1, 1'b0, dummy);
    rd(A_STAT, v); check("R8 rx strobe clears", v, 16'h0010);
    cyc('0, 1'b0, 1'b0, A_NONE, '0, 1'b0, 1'b1, dummy);
    rd(A_STAT, v); check("R8 tx strobe clears", v, 16'h0000);
  endtask

  task automatic t_levels();
    logic [15:0] v;
    rx_shift_full = 1'b1; bus_busy = 1'b0;
    rd(A_STAT, v); check("R9 shift full bit", v, 16'h0800);
    rx_shift_full = 1'b0; bus_busy = 1'b1;
    rd(A_STAT, v); check("R9 busy bit", v, 16'h1000);
    bus_busy = 1'b0;
  endtask

  task automatic t_unmapped();
    logic [15:0] v;
    wr(A_MASK, 16'h0005);
    wr(A_NONE, 16'hFFFF);
    rd(A_NONE, v); check("R11 unmapped reads zero", v, 16'h0000);
    rd(A_MASK, v); check("R11 mask untouched", v, 16'h0005);
  endtask

  task automatic t_clash();
    logic [15:0] v;
    logic [15:0] dummy;
    wr(A_MASK, 16'h007F);
    pulse(7'h01);
    cyc(7'h01, 1'b1, 1'b0, A_VEC, '0, 1'b0, 1'b0, v);
    check("R10 vector read returns code", v, 16'h0001);
    rd(A_STAT, v); check("R10 event beats vector ack", v, 16'h0001);
    wr(A_STAT, 16'h0001);
    pulse(7'h20);
    cyc(7'h20, 1'b0, 1'b1, A_STAT, 16'h0020, 1'b0, 1'b0, dummy);
    rd(A_STAT, v); check("R10 event beats write-one", v, 16'h0020);
    wr(A_STAT, 16'h0020);
    cyc(7'h08, 1'b0, 1'b0, A_NONE, '0, 1'b1, 1'b0, dummy);
    rd(A_STAT, v); check("R10 event beats rx strobe", v, 16'h0008);
  endtask

  initial begin
    rst_n = 1'b0;
    ev = '0; reg_rd = 1'b0; reg_wr = 1'b0; reg_addr = A_NONE; reg_wdata = '0;
    rx_data_taken = 1'b0; tx_data_loaded = 1'b0;
    rx_shift_full = 1'b0; bus_busy = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_masked_latch();
    t_mask_and_ack();
    t_priority_walk();
    t_mask_select();
    t_w1c_and_strobes();
    t_levels();
    t_unmapped();
    t_clash();
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
    $finish;
  end

  initial begin
    #800000;
    n_checks++;
    n_err++;
    $display("FAIL watchdog: actual running expected finished");
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
    $finish;
  end
endmodule